// File: doc/BRIEF.md
# Virtually Tagged Write-Back Data Cache

This block is a write-back data cache for a 32-bit big-endian processor. Each line holds one word. Each line's tag carries three things: the virtual address bits above the cache size, the process identifier that owned the line when it was filled, and a dirty flag in bit 0. The processor issues a read or write of 1, 2 or 4 bytes and waits. A hit completes from the arrays. On a miss the block first writes back a dirty victim and then fills the line. Both steps go through an external address translator and a word-wide memory port. A translation fault ends the access with no data. Accesses outside the cacheable window skip the cache and go straight to memory.

The controller is a stall-based state machine with these states:
- `ST_IDLE` accepts a request.
- `ST_LOOKUP` compares tags and picks hit, bypass, write-back or fill.
- `ST_WB_XLAT` translates the victim address.
- `ST_WB_WRITE` stores the victim word.
- `ST_TRANSLATE` translates the request address.
- `ST_FILL` reads the new word.
- `ST_BYPASS` does an uncached memory access.
- `ST_RESPOND` returns the result and applies any write merge.

The transitions are:
- IDLE→LOOKUP on an accepted request.
- LOOKUP→BYPASS when the address is outside the window.
- LOOKUP→RESPOND on a hit.
- LOOKUP→WB_XLAT on a miss with a dirty victim.
- LOOKUP→TRANSLATE on a miss with a clean victim.
- WB_XLAT→WB_WRITE when translation succeeds, and WB_XLAT→RESPOND on a fault.
- WB_WRITE→TRANSLATE when the memory acknowledges.
- TRANSLATE→FILL when translation succeeds, and TRANSLATE→RESPOND on a fault.
- FILL→RESPOND and BYPASS→RESPOND when the memory acknowledges.
- RESPOND→IDLE always.

The replaced way comes from a round-robin counter. The counter steps once per miss, modulo the associativity parameter. With the default of one way, every miss replaces the only line at the index.

Top module: `vtc_cache`

## Requirements
- R1: After reset every tag holds 0xFFFF0000, so the first access to any cacheable address misses and fetches from memory. `req_ready` is 1, and `resp_valid`, `mem_req` and `xlat_req` are 0.
- R2: An address is cacheable when `(addr & 0xFE000000) == 0x10000000`, which covers 0x1000_0000 through 0x11FF_FFFF. Any other address makes one memory access at the word-aligned address with no translation.
- R3: A hit needs address bits [31:13] to equal the stored tag bits [31:13]. The process identifier is not compared, and a hit makes no memory access and no translation.
- R4: A miss whose victim is clean makes one translation of the request address, using the current process identifier and the request's write flag. It then makes one memory read at the translated word address. The new tag is address bits [31:13], the current identifier in bits [12:1], and a clear dirty flag.
- R5: A miss whose victim has tag bit 0 set first translates the address {tag[31:13], index, 2'b00} as a write. It then writes the victim word to the translated address with all four byte enables before the fill.
- R6: Reads are big-endian and zero-extended. Size code 0 is a byte, 1 is a halfword and 2 is a word. The byte at offset k is returned from bits [31-8k:24-8k]. A halfword uses address bit 1 only: 0 selects [31:16] and 1 selects [15:0].
- R7: A write of a byte or halfword replicates the value across the word and merges it into the stored word under a mask, placed the same way as in R6. The other lanes are kept, and the line is marked dirty.
- R8: If either translation faults, the response has `resp_fault` 1 and data 0, and the fill makes no memory access. Tags and data are left as they were, including a still-valid old line.
- R9: `resp_valid` is a single-cycle pulse for each accepted request. `req_ready` is 1 only while the controller is idle.
- R10: The write-back translation uses the process identifier stored in tag bits [12:1] of the victim, not the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request strobe |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data, right-aligned for sub-word |
| req_pid | input | 12 | Current process identifier |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Access aborted by a translation fault |
| resp_rdata | output | 32 | Load result, zero-extended |
| xlat_req | output | 1 | Translation request, held until acknowledged |
| xlat_write | output | 1 | Translation is for a write access |
| xlat_vaddr | output | 32 | Virtual address to translate |
| xlat_pid | output | 12 | Process identifier for the translation |
| xlat_ack | input | 1 | Translation result valid |
| xlat_fault | input | 1 | Translation failed |
| xlat_paddr | input | 32 | Physical address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_write | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned physical address |
| mem_be | output | 4 | Byte enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data |

## Verification
Two functions can fall into one access: the eviction of a dirty line and the abort caused by a translation fault on the fill. The bench provokes this with a store to a faulting page that maps to the index of a dirty line owned by a different process. It checks four things:
- the victim word reaches memory at the address translated with the owner's identifier;
- the response carries the fault with zero data;
- no fill read follows;
- a later load of the old line still hits with its data intact.

A second case combines the write-back with a successful fill, where both translations and both memory transfers happen inside one access.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    localparam int WORD_W = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [WORD_W-1:0] TAG_INIT = 32'hFFFF_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB_XLAT,
        ST_WB_WRITE,
        ST_TRANSLATE,
        ST_FILL,
        ST_BYPASS,
        ST_RESPOND
    } vtc_state_e;

endpackage

// File: rtl/vtc_tag_store.sv
module vtc_tag_store
    import vtc_pkg::*;
#(
    parameter int WAYS  = 1,
    parameter int IDX_W = 11,
    parameter int WAY_W = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [WAYS-1:0][WORD_W-1:0]  rd_tags,
    input  logic                         we,
    input  logic [WAY_W-1:0]             we_way,
    input  logic [IDX_W-1:0]             we_idx,
    input  logic [WORD_W-1:0]            we_tag
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [WORD_W-1:0] tag_mem [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < SETS; i++) begin
                    tag_mem[i] <= TAG_INIT;
                end
            end else if (we && (we_way == WAY_W'(w))) begin
                tag_mem[we_idx] <= we_tag;
            end
        end

        assign rd_tags[w] = tag_mem[rd_idx];
    end

endmodule

// File: rtl/vtc_data_store.sv
module vtc_data_store
    import vtc_pkg::*;
#(
    parameter int WAYS  = 1,
    parameter int IDX_W = 11,
    parameter int WAY_W = 1
) (
    input  logic                         clk,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [WAYS-1:0][WORD_W-1:0]  rd_words,
    input  logic                         we,
    input  logic [WAY_W-1:0]             we_way,
    input  logic [IDX_W-1:0]             we_idx,
    input  logic [WORD_W-1:0]            we_word
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [WORD_W-1:0] word_mem [SETS];

        always_ff @(posedge clk) begin
            if (we && (we_way == WAY_W'(w))) begin
                word_mem[we_idx] <= we_word;
            end
        end

        assign rd_words[w] = word_mem[rd_idx];
    end

endmodule

// File: rtl/vtc_lane_unit.sv
module vtc_lane_unit
    import vtc_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        offset,
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_val,
    output logic [WORD_W-1:0] wr_repl,
    output logic [WORD_W-1:0] wr_merged,
    output logic [3:0]        lane_be
);
    logic [4:0]        shamt;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] mask;

    // Big-endian lane placement: the byte offset is inverted before shifting.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                shamt   = {offset ^ 2'b11, 3'b000};
                base    = 32'h0000_00FF;
                wr_repl = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                shamt   = {~offset[1], 4'b0000};
                base    = 32'h0000_FFFF;
                wr_repl = {2{wdata[15:0]}};
            end
            default: begin
                shamt   = 5'd0;
                base    = '1;
                wr_repl = wdata;
            end
        endcase
        mask      = base << shamt;
        rd_val    = (word_in >> shamt) & base;
        wr_merged = (wr_repl & mask) | (word_in & ~mask);
    end

    for (genvar b = 0; b < 4; b++) begin : g_be
        assign lane_be[b] = |mask[8*b +: 8];
    end

endmodule

// File: rtl/vtc_cache.sv
module vtc_cache
    import vtc_pkg::*;
#(
    parameter int          CACHE_BYTES = 8192,
    parameter int          WAYS        = 1,
    parameter logic [31:0] WIN_MASK    = 32'hFE00_0000,
    parameter logic [31:0] WIN_BASE    = 32'h1000_0000,
    parameter int          SET_BITS    = $clog2(CACHE_BYTES / WAYS),
    parameter int          PID_W       = SET_BITS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [PID_W-1:0]  req_pid,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [31:0]       resp_rdata,
    output logic              xlat_req,
    output logic              xlat_write,
    output logic [31:0]       xlat_vaddr,
    output logic [PID_W-1:0]  xlat_pid,
    input  logic              xlat_ack,
    input  logic              xlat_fault,
    input  logic [31:0]       xlat_paddr,
    output logic              mem_req,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int IDX_W = SET_BITS - 2;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    vtc_state_e state_q, state_d;

    logic [31:0]       addr_q, wdata_q, paddr_q, byp_word_q;
    logic [PID_W-1:0]  pid_q;
    logic [1:0]        size_q;
    logic              wr_q, abort_q, bypass_q;
    logic [WAY_W-1:0]  way_q, rr_q, rr_next;

    logic [IDX_W-1:0]             idx;
    logic                         cacheable;
    logic [WAYS-1:0][31:0]        rd_tags, rd_words;
    logic [31:0]                  cur_tag, cur_word, src_word;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit, vic_dirty;
    logic [WAY_W-1:0]             hit_way;

    logic              tag_we, data_we;
    logic [31:0]       tag_wdata, data_wdata;
    logic [31:0]       lane_rd, lane_repl, lane_merged;
    logic [3:0]        lane_be;

    assign idx       = addr_q[SET_BITS-1:2];
    assign cacheable = (addr_q & WIN_MASK) == WIN_BASE;
    assign cur_tag   = rd_tags[way_q];
    assign cur_word  = rd_words[way_q];
    assign vic_dirty = rd_tags[rr_q][0];
    assign src_word  = bypass_q ? byp_word_q : cur_word;
    assign rr_next   = (rr_q == LAST_WAY) ? '0 : rr_q + 1'b1;

    // Hit detection: only the bits above the cache size take part.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = rd_tags[w][31:SET_BITS] == addr_q[31:SET_BITS];
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w] && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    vtc_tag_store #(.WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx),
        .rd_tags (rd_tags),
        .we      (tag_we),
        .we_way  (way_q),
        .we_idx  (idx),
        .we_tag  (tag_wdata)
    );

    vtc_data_store #(.WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_data (
        .clk      (clk),
        .rd_idx   (idx),
        .rd_words (rd_words),
        .we       (data_we),
        .we_way   (way_q),
        .we_idx   (idx),
        .we_word  (data_wdata)
    );

    vtc_lane_unit u_lane (
        .size      (size_q),
        .offset    (addr_q[1:0]),
        .word_in   (src_word),
        .wdata     (wdata_q),
        .rd_val    (lane_rd),
        .wr_repl   (lane_repl),
        .wr_merged (lane_merged),
        .lane_be   (lane_be)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (!cacheable)     state_d = ST_BYPASS;
                else if (hit)       state_d = ST_RESPOND;
                else if (vic_dirty) state_d = ST_WB_XLAT;
                else                state_d = ST_TRANSLATE;
            end
            ST_WB_XLAT:   if (xlat_ack) state_d = xlat_fault ? ST_RESPOND : ST_WB_WRITE;
            ST_WB_WRITE:  if (mem_ack)  state_d = ST_TRANSLATE;
            ST_TRANSLATE: if (xlat_ack) state_d = xlat_fault ? ST_RESPOND : ST_FILL;
            ST_FILL:      if (mem_ack)  state_d = ST_RESPOND;
            ST_BYPASS:    if (mem_ack)  state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
        endcase
    end

    // Request and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            pid_q      <= '0;
            size_q     <= SZ_WORD;
            wr_q       <= 1'b0;
            abort_q    <= 1'b0;
            bypass_q   <= 1'b0;
            way_q      <= '0;
            rr_q       <= '0;
            paddr_q    <= '0;
            byp_word_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    wdata_q  <= req_wdata;
                    pid_q    <= req_pid;
                    size_q   <= req_size;
                    wr_q     <= req_write;
                    abort_q  <= 1'b0;
                    bypass_q <= 1'b0;
                end
                ST_LOOKUP: begin
                    bypass_q <= !cacheable;
                    way_q    <= hit ? hit_way : rr_q;
                    if (cacheable && !hit) rr_q <= rr_next;
                end
                ST_WB_XLAT, ST_TRANSLATE: if (xlat_ack) begin
                    paddr_q <= xlat_paddr;
                    abort_q <= xlat_fault;
                end
                ST_BYPASS: if (mem_ack) byp_word_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Outputs and array write strobes
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_fault = 1'b0;
        resp_rdata = '0;
        xlat_req   = 1'b0;
        xlat_write = 1'b0;
        xlat_vaddr = '0;
        xlat_pid   = '0;
        mem_req    = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = '0;
        mem_be     = 4'h0;
        mem_wdata  = '0;
        tag_we     = 1'b0;
        tag_wdata  = '0;
        data_we    = 1'b0;
        data_wdata = '0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LOOKUP: ;
            ST_WB_XLAT: begin
                xlat_req   = 1'b1;
                xlat_write = 1'b1;
                xlat_vaddr = {cur_tag[31:SET_BITS], idx, 2'b00};
                xlat_pid   = cur_tag[SET_BITS-1:1];
            end
            ST_WB_WRITE: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
                mem_addr  = paddr_q & ~32'h3;
                mem_be    = 4'hF;
                mem_wdata = cur_word;
            end
            ST_TRANSLATE: begin
                xlat_req   = 1'b1;
                xlat_write = wr_q;
                xlat_vaddr = addr_q;
                xlat_pid   = pid_q;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = paddr_q & ~32'h3;
                mem_be   = 4'hF;
                if (mem_ack) begin
                    tag_we     = 1'b1;
                    tag_wdata  = {addr_q[31:SET_BITS], pid_q, 1'b0};
                    data_we    = 1'b1;
                    data_wdata = mem_rdata;
                end
            end
            ST_BYPASS: begin
                mem_req   = 1'b1;
                mem_write = wr_q;
                mem_addr  = addr_q & ~32'h3;
                mem_be    = lane_be;
                mem_wdata = lane_repl;
            end
            ST_RESPOND: begin
                resp_valid = 1'b1;
                resp_fault = abort_q;
                if (!abort_q && !wr_q) resp_rdata = lane_rd;
                if (!abort_q && !bypass_q && wr_q) begin
                    tag_we     = 1'b1;
                    tag_wdata  = cur_tag | 32'h1;
                    data_we    = 1'b1;
                    data_wdata = lane_merged;
                end
            end
        endcase
    end

    // Assertions
    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_rdata == '0));

    a_r8_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && xlat_ack && xlat_fault) |=> !mem_req);

    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && cacheable) |-> $onehot0(hit_vec));

    a_r2_bypass_no_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_LOOKUP && bypass_q) |-> !xlat_req);

    a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r4_xlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && !xlat_ack) |=> (xlat_req && $stable(xlat_vaddr)));

endmodule

// File: tb/test_vtc_cache.sv
module test_vtc_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [11:0] req_pid = '0;
    logic        resp_valid, resp_fault;
    logic [31:0] resp_rdata;
    logic        xlat_req, xlat_write;
    logic [31:0] xlat_vaddr;
    logic [11:0] xlat_pid;
    logic        xlat_ack = 1'b0;
    logic        xlat_fault;
    logic [31:0] xlat_paddr;
    logic        mem_req, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    vtc_cache i_vtc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .req_pid(req_pid),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
        .xlat_req(xlat_req), .xlat_write(xlat_write), .xlat_vaddr(xlat_vaddr),
        .xlat_pid(xlat_pid), .xlat_ack(xlat_ack), .xlat_fault(xlat_fault), .xlat_paddr(xlat_paddr),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Translator and memory models: one-cycle acknowledge, fixed mapping.
    assign xlat_paddr = xlat_vaddr + 32'h2000_0000;
    assign xlat_fault = xlat_vaddr[31:16] == 16'h1100;
    assign mem_rdata  = mem_addr ^ 32'h5A5A_5A5A;

    int          mem_cnt = 0, xl_cnt = 0;
    logic [31:0] wr_addr_log = '0, wr_data_log = '0, xl_prev_vaddr = '0;
    logic [3:0]  wr_be_log = '0;
    logic [11:0] xl_prev_pid = '0, xl_last_pid = '0;
    logic [31:0] xl_last_vaddr = '0;

    always @(posedge clk) begin
        mem_ack  <= mem_req && !mem_ack;
        xlat_ack <= xlat_req && !xlat_ack;
        if (mem_req && mem_ack) begin
            mem_cnt <= mem_cnt + 1;
            if (mem_write) begin
                wr_addr_log <= mem_addr;
                wr_data_log <= mem_wdata;
                wr_be_log   <= mem_be;
            end
        end
        if (xlat_req && xlat_ack) begin
            xl_cnt        <= xl_cnt + 1;
            xl_prev_pid   <= xl_last_pid;
            xl_prev_vaddr <= xl_last_vaddr;
            xl_last_pid   <= xlat_pid;
            xl_last_vaddr <= xlat_vaddr;
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [11:0] pid,
                          output logic [31:0] rd, output logic flt,
                          output int dmem, output int dxl);
        int m0;
        int x0;
        logic seen;
        m0 = mem_cnt;
        x0 = xl_cnt;
        seen = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = addr; req_wdata = wd; req_pid = pid;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (resp_valid) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        check("R9", "response seen", {31'd0, seen}, 32'd1);
        rd  = resp_rdata;
        flt = resp_fault;
        @(negedge clk);
        check("R9", "single-cycle response", {31'd0, resp_valid}, 32'd0);
        dmem = mem_cnt - m0;
        dxl  = xl_cnt - x0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [11:0] pid;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  dmem;
        logic [3:0]  dxl;
        logic [15:0] tag;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b0, 2'd2, 32'h1000_0100, 32'h0,         12'd1, 1'b1, 32'h6A5A_5B5A, 4'd1, 4'd1, "R1"}, // cold miss, R4 fill
        '{1'b0, 2'd0, 32'h1000_0101, 32'h0,         12'd1, 1'b1, 32'h0000_005A, 4'd0, 4'd0, "R6"},
        '{1'b0, 2'd1, 32'h1000_0102, 32'h0,         12'd2, 1'b1, 32'h0000_5B5A, 4'd0, 4'd0, "R3"}, // other pid hits
        '{1'b1, 2'd0, 32'h1000_0103, 32'h0000_00EE, 12'd1, 1'b0, 32'h0,         4'd0, 4'd0, "R7"},
        '{1'b1, 2'd1, 32'h1000_0100, 32'h0000_1234, 12'd1, 1'b0, 32'h0,         4'd0, 4'd0, "R7"},
        '{1'b0, 2'd2, 32'h1000_0100, 32'h0,         12'd1, 1'b1, 32'h1234_5BEE, 4'd0, 4'd0, "R7"},
        '{1'b0, 2'd0, 32'h1000_0100, 32'h0,         12'd1, 1'b1, 32'h0000_0012, 4'd0, 4'd0, "R6"},
        '{1'b0, 2'd2, 32'h2000_0040, 32'h0,         12'd1, 1'b1, 32'h7A5A_5A1A, 4'd1, 4'd0, "R2"},
        '{1'b0, 2'd0, 32'h2000_0043, 32'h0,         12'd1, 1'b1, 32'h0000_001A, 4'd1, 4'd0, "R2"},
        '{1'b1, 2'd2, 32'h1000_0204, 32'hCAFE_F00D, 12'd4, 1'b0, 32'h0,         4'd1, 4'd1, "R4"},
        '{1'b0, 2'd2, 32'h1000_0204, 32'h0,         12'd7, 1'b1, 32'hCAFE_F00D, 4'd0, 4'd0, "R3"},
        '{1'b0, 2'd2, 32'h11FF_FFFC, 32'h0,         12'd1, 1'b1, 32'h6BA5_A5A6, 4'd1, 4'd1, "R2"},
        '{1'b0, 2'd2, 32'h1200_0000, 32'h0,         12'd1, 1'b1, 32'h485A_5A5A, 4'd1, 4'd0, "R2"}
    };

    initial begin
        logic [31:0] rd;
        logic        flt;
        int          dm, dx;
        string       t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1", "no response after reset", {31'd0, resp_valid}, 32'd0);
        check("R1", "no memory request after reset", {31'd0, mem_req}, 32'd0);
        check("R1", "no translation after reset", {31'd0, xlat_req}, 32'd0);

        for (int i = 0; i < 13; i++) begin
            t = string'(VECS[i].tag);
            access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd, VECS[i].pid, rd, flt, dm, dx);
            if (VECS[i].chk) check(t, "read data", rd, VECS[i].exp);
            check(t, "no fault", {31'd0, flt}, 32'd0);
            check(t, "memory accesses", dm, {28'd0, VECS[i].dmem});
            check(t, "translations", dx, {28'd0, VECS[i].dxl});
        end

        // R5/R10: dirty line (pid 1) evicted by a pid 3 miss on the same index
        access(1'b0, 2'd2, 32'h1000_2100, 32'h0, 12'd3, rd, flt, dm, dx);
        check("R5", "evict read data", rd, 32'h6A5A_7B5A);
        check("R5", "evict memory accesses", dm, 32'd2);
        check("R5", "evict translations", dx, 32'd2);
        check("R5", "write-back address", wr_addr_log, 32'h3000_0100);
        check("R5", "write-back data", wr_data_log, 32'h1234_5BEE);
        check("R5", "write-back enables", {28'd0, wr_be_log}, 32'hF);
        check("R5", "write-back vaddr", xl_prev_vaddr, 32'h1000_0100);
        check("R10", "write-back pid", {20'd0, xl_prev_pid}, 32'd1);
        check("R4", "fill pid", {20'd0, xl_last_pid}, 32'd3);

        // R8/R10: fill fault after a write-back of a pid 4 line
        access(1'b1, 2'd2, 32'h1100_0204, 32'hDEAD_BEEF, 12'd1, rd, flt, dm, dx);
        check("R8", "fault flag", {31'd0, flt}, 32'd1);
        check("R8", "fault data", rd, 32'h0);
        check("R8", "only write-back reached memory", dm, 32'd1);
        check("R8", "two translations", dx, 32'd2);
        check("R5", "second write-back data", wr_data_log, 32'hCAFE_F00D);
        check("R10", "second write-back pid", {20'd0, xl_prev_pid}, 32'd4);
        access(1'b0, 2'd2, 32'h1000_0204, 32'h0, 12'd1, rd, flt, dm, dx);
        check("R8", "old line still hits", dm, 32'd0);
        check("R8", "old line data kept", rd, 32'hCAFE_F00D);

        // R8: fault on a clean miss
        access(1'b0, 2'd0, 32'h1100_0010, 32'h0, 12'd1, rd, flt, dm, dx);
        check("R8", "clean-miss fault flag", {31'd0, flt}, 32'd1);
        check("R8", "clean-miss fault data", rd, 32'h0);
        check("R8", "clean-miss no memory", dm, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R9 watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule